// File: doc/BRIEF.md
# Transfer FIFO with Threshold-Driven DMA Events

This block is a 32-bit word FIFO placed between a host/DMA port and the data path of a memory-card controller. It works in one of two directions, chosen by a mode input. In card-read mode the card side writes words into the FIFO and the host drains them through a receive data port. In card-write mode the host fills the FIFO through a transmit data port and the card side takes words out. The card's bit-serial engine is not part of the block; its side is a plain word push or pop strobe.

A move counter counts the words that cross the card side of the FIFO: words captured from the card in card-read mode and words taken by the card in card-write mode. When the count reaches the programmed burst level (16 or 32 bytes), the block issues a one-cycle DMA event for that direction and an interrupt event that goes with it, then restarts the count. A new event waits until the requester has acknowledged the previous one. Host writes carry byte enables so that a final partial word can be stored. Lanes that are not enabled reach the card side as zero. Full and empty flags are exported as status only.

Top module: `xfer_fifo_dma`

## Requirements
- R1: While `rst_n` is low at a clock edge, the FIFO becomes empty (`fifo_empty`=1, `fifo_full`=0) and all four event outputs read 0.
- R2: Words leave the FIFO in the order they were accepted. The head word is shown on both `host_rd_data` and `card_pop_data` whenever the FIFO is not empty.
- R3: The FIFO holds 16 words. `fifo_full` is 1 at 16 words and `fifo_empty` is 1 at 0 words. A push offered while full is refused, even if a pop happens in the same cycle. A pop offered while empty is refused.
- R4: In card-read mode (`dir_write`=0), every accepted card push counts one move. When the count reaches the level (4 words when `level_sel`=0, 8 words when `level_sel`=1), `dma_rd_evt` is 1 for exactly the one cycle after the clock edge that accepted that move, and the count restarts from 0.
- R5: In card-write mode (`dir_write`=1), every accepted card pop counts one move. The level and timing are the same as in R4, and the event is raised on `dma_wr_evt`.
- R6: `irq_rd_evt` and `irq_wr_evt` pulse in exactly the same cycles as `dma_rd_evt` and `dma_wr_evt` respectively.
- R7: After an event, no further event is issued until `dma_ack` has been seen high at a clock edge. Moves made while the event is pending raise the count no higher than the level. If the count is at the level when the acknowledge is taken at edge k, the next event is visible after edge k+1.
- R8: In card-write mode, a host write is accepted only with `host_wr_be` equal to 1111, 1110, 1100 or 1000 (bit i enables byte lane i, data bits 8i+7..8i). Any other pattern is ignored. Disabled lanes are stored as zero, and the stored enables appear on `card_pop_be` with the word. Card pushes are stored with enables 1111.
- R9: In card-read mode, host writes and card pops have no effect. In card-write mode, card pushes and host reads have no effect.
- R10: `fifo_clear` high at a clock edge empties the FIFO, zeroes the move count, drops any pending event and clears the event outputs in that single cycle. Pushes and pops offered in the same cycle are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fifo_clear | input | 1 | Clears FIFO, move count and pending event |
| dir_write | input | 1 | 1 = card-write mode, 0 = card-read mode |
| level_sel | input | 1 | Burst level: 0 = 4 words, 1 = 8 words |
| host_wr_en | input | 1 | Host write strobe on the transmit data port |
| host_wr_data | input | 32 | Host write word |
| host_wr_be | input | 4 | Byte enables of the host write |
| host_rd_en | input | 1 | Host read strobe on the receive data port |
| host_rd_data | output | 32 | Head word seen by the host |
| card_push_en | input | 1 | Card-side word capture strobe |
| card_push_data | input | 32 | Word captured from the card |
| card_pop_en | input | 1 | Card-side word take strobe |
| card_pop_data | output | 32 | Head word seen by the card side |
| card_pop_be | output | 4 | Byte enables stored with the head word |
| dma_ack | input | 1 | Acknowledge of the pending DMA event |
| dma_rd_evt | output | 1 | DMA event, card-read direction |
| dma_wr_evt | output | 1 | DMA event, card-write direction |
| irq_rd_evt | output | 1 | Interrupt event paired with dma_rd_evt |
| irq_wr_evt | output | 1 | Interrupt event paired with dma_wr_evt |
| fifo_full | output | 1 | FIFO holds 16 words |
| fifo_empty | output | 1 | FIFO holds no words |

## Verification
Two things can land on the same clock edge: the requester's acknowledge of a pending event, and a move that takes the count to or past the level. The acknowledge must release the held count, and the event must appear one cycle later rather than being lost or doubled. The bench provokes this directly by filling past the level with no acknowledge and then acknowledging. It also drives random acknowledges, moves and level changes, so the two often fall on one edge. Every cycle the outputs are compared with a bench model built from R4, R5 and R7. A clear that coincides with a push and a pending event is checked the same way.

// File: rtl/xfer_fifo_pkg.sv
// Package: shared entry type and byte-enable rule for the transfer FIFO.
// Assumes a 32-bit word split into four byte lanes.
package xfer_fifo_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned LANES  = WORD_W / 8;

    // One FIFO slot: the lane enables stored beside the word.
    typedef struct packed {
        logic [LANES-1:0]  be;
        logic [WORD_W-1:0] data;
    } fifo_entry_t;

    // Legal enables: a non-zero run of ones starting at the top lane.
    function automatic logic be_pattern_ok(input logic [LANES-1:0] be);
        logic [LANES-1:0] inv;
        inv = ~be;
        return (be != '0) && ((inv & (inv + 1'b1)) == '0);
    endfunction

endpackage

// File: rtl/xfer_fifo_store.sv
// Module: word storage with wrap pointers and full/empty flags.
// Assumes push and pop arrive already qualified against full and empty.
// DEPTH must be a power of two.
module xfer_fifo_store
    import xfer_fifo_pkg::*;
#(
    parameter int unsigned DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clear,
    input  logic        push,
    input  fifo_entry_t push_entry,
    input  logic        pop,
    output fifo_entry_t head,
    output logic        full,
    output logic        empty
);

    localparam int unsigned IDX_W = $clog2(DEPTH);

    fifo_entry_t      mem [DEPTH];
    logic [IDX_W:0]   wr_ptr;
    logic [IDX_W:0]   rd_ptr;

    // Write pointer: advances on each accepted push.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wr_ptr <= '0;
        end else if (push) begin
            wr_ptr <= wr_ptr + 1'b1;
        end
    end

    // Read pointer: advances on each accepted pop.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            rd_ptr <= '0;
        end else if (pop) begin
            rd_ptr <= rd_ptr + 1'b1;
        end
    end

    // Storage array: captures the pushed entry at the write index.
    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr[IDX_W-1:0]] <= push_entry;
        end
    end

    assign head  = mem[rd_ptr[IDX_W-1:0]];
    assign empty = (wr_ptr == rd_ptr);
    assign full  = (wr_ptr[IDX_W] != rd_ptr[IDX_W]) &&
                   (wr_ptr[IDX_W-1:0] == rd_ptr[IDX_W-1:0]);

endmodule

// File: rtl/xfer_port_steer.sv
// Module: routes host and card strobes to push/pop by direction,
// screens host byte enables and zeroes disabled lanes.
// Assumes full/empty come from the storage of the current cycle.
module xfer_port_steer
    import xfer_fifo_pkg::*;
(
    input  logic              dir_write,
    input  logic              host_wr_en,
    input  logic [WORD_W-1:0] host_wr_data,
    input  logic [LANES-1:0]  host_wr_be,
    input  logic              host_rd_en,
    input  logic              card_push_en,
    input  logic [WORD_W-1:0] card_push_data,
    input  logic              card_pop_en,
    input  logic              full,
    input  logic              empty,
    output logic              push,
    output logic              pop,
    output fifo_entry_t       push_entry,
    output logic              move
);

    logic              push_req;
    logic              pop_req;
    logic [WORD_W-1:0] host_masked;

    // Lane masking of the host word, one byte per generated slice.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign host_masked[l*8 +: 8] = host_wr_be[l] ? host_wr_data[l*8 +: 8] : 8'h00;
    end

    // Request selection: which side may push and which may pop.
    always_comb begin
        push_req = dir_write ? (host_wr_en && be_pattern_ok(host_wr_be)) : card_push_en;
        pop_req  = dir_write ? card_pop_en : host_rd_en;
    end

    // Qualification and entry building; the move is the card-side transfer.
    always_comb begin
        push            = push_req && !full;
        pop             = pop_req && !empty;
        push_entry.be   = dir_write ? host_wr_be : '1;
        push_entry.data = dir_write ? host_masked : card_push_data;
        move            = dir_write ? pop : push;
    end

endmodule

// File: rtl/xfer_burst_counter.sv
// Module: counts card-side moves and raises a registered one-cycle event
// when the count reaches the selected level. Holds at the level while a
// previous event waits for its acknowledge.
module xfer_burst_counter #(
    parameter int unsigned LEVEL_LO = 4,
    parameter int unsigned LEVEL_HI = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic dir_write,
    input  logic level_sel,
    input  logic move,
    input  logic dma_ack,
    output logic rd_evt,
    output logic wr_evt
);

    localparam int unsigned CNT_W = $clog2(LEVEL_HI + 1);

    logic [CNT_W-1:0] cnt_q;
    logic             pend_q;
    logic [CNT_W:0]   level;
    logic [CNT_W:0]   sum;
    logic             at_level;
    logic             fire;

    // Threshold compare and fire decision for this edge.
    always_comb begin
        level    = level_sel ? (CNT_W+1)'(LEVEL_HI) : (CNT_W+1)'(LEVEL_LO);
        sum      = {1'b0, cnt_q} + {{CNT_W{1'b0}}, move};
        at_level = (sum >= level);
        fire     = at_level && !pend_q;
    end

    // Move counter: restarts on fire, saturates at the level while pending.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
        end else if (fire) begin
            cnt_q <= '0;
        end else if (at_level) begin
            cnt_q <= level[CNT_W-1:0];
        end else begin
            cnt_q <= sum[CNT_W-1:0];
        end
    end

    // Pending flag: set by an event, dropped by the acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            pend_q <= 1'b0;
        end else begin
            pend_q <= fire || (pend_q && !dma_ack);
        end
    end

    // Event registers: one-cycle pulse per direction.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            rd_evt <= 1'b0;
            wr_evt <= 1'b0;
        end else begin
            rd_evt <= fire && !dir_write;
            wr_evt <= fire && dir_write;
        end
    end

endmodule

// File: rtl/xfer_fifo_dma.sv
// Module: transfer FIFO top. Joins storage, direction steering and the
// burst counter. Interrupt events mirror the DMA events.
// Assumes a 16-word depth and levels of 4 or 8 words by default.
module xfer_fifo_dma
    import xfer_fifo_pkg::*;
#(
    parameter int unsigned DEPTH_WORDS = 16,
    parameter int unsigned LEVEL_LO    = 4,
    parameter int unsigned LEVEL_HI    = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        fifo_clear,
    input  logic        dir_write,
    input  logic        level_sel,
    input  logic        host_wr_en,
    input  logic [31:0] host_wr_data,
    input  logic [3:0]  host_wr_be,
    input  logic        host_rd_en,
    output logic [31:0] host_rd_data,
    input  logic        card_push_en,
    input  logic [31:0] card_push_data,
    input  logic        card_pop_en,
    output logic [31:0] card_pop_data,
    output logic [3:0]  card_pop_be,
    input  logic        dma_ack,
    output logic        dma_rd_evt,
    output logic        dma_wr_evt,
    output logic        irq_rd_evt,
    output logic        irq_wr_evt,
    output logic        fifo_full,
    output logic        fifo_empty
);

    logic        push;
    logic        pop;
    logic        move;
    fifo_entry_t push_entry;
    fifo_entry_t head;

    xfer_port_steer u_steer (
        .dir_write      (dir_write),
        .host_wr_en     (host_wr_en),
        .host_wr_data   (host_wr_data),
        .host_wr_be     (host_wr_be),
        .host_rd_en     (host_rd_en),
        .card_push_en   (card_push_en),
        .card_push_data (card_push_data),
        .card_pop_en    (card_pop_en),
        .full           (fifo_full),
        .empty          (fifo_empty),
        .push           (push),
        .pop            (pop),
        .push_entry     (push_entry),
        .move           (move)
    );

    xfer_fifo_store #(.DEPTH(DEPTH_WORDS)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (fifo_clear),
        .push       (push),
        .push_entry (push_entry),
        .pop        (pop),
        .head       (head),
        .full       (fifo_full),
        .empty      (fifo_empty)
    );

    xfer_burst_counter #(.LEVEL_LO(LEVEL_LO), .LEVEL_HI(LEVEL_HI)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (fifo_clear),
        .dir_write (dir_write),
        .level_sel (level_sel),
        .move      (move),
        .dma_ack   (dma_ack),
        .rd_evt    (dma_rd_evt),
        .wr_evt    (dma_wr_evt)
    );

    assign host_rd_data  = head.data;
    assign card_pop_data = head.data;
    assign card_pop_be   = head.be;
    assign irq_rd_evt    = dma_rd_evt;
    assign irq_wr_evt    = dma_wr_evt;

endmodule

// File: rtl/xfer_fifo_dma_checker.sv
// Module: port-level properties of the transfer FIFO, bound to the top.
module xfer_fifo_dma_checker
    import xfer_fifo_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       fifo_clear,
    input logic       dir_write,
    input logic       host_wr_en,
    input logic [3:0] host_wr_be,
    input logic       card_push_en,
    input logic       dma_ack,
    input logic       dma_rd_evt,
    input logic       dma_wr_evt,
    input logic       fifo_full,
    input logic       fifo_empty
);

    logic ack_seen;

    // Tracks whether an acknowledge has been seen since the last event.
    always_ff @(posedge clk) begin
        if (!rst_n || fifo_clear) begin
            ack_seen <= 1'b1;
        end else if (dma_ack) begin
            ack_seen <= 1'b1;
        end else if (dma_rd_evt || dma_wr_evt) begin
            ack_seen <= 1'b0;
        end
    end

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (fifo_empty && !fifo_full && !dma_rd_evt && !dma_wr_evt));

    assert_full_empty_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_full && fifo_empty));

    assert_rd_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dma_rd_evt |=> !dma_rd_evt);

    assert_wr_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dma_wr_evt |=> !dma_wr_evt);

    assert_no_evt_while_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_rd_evt || dma_wr_evt) |-> ack_seen);

    assert_illegal_be_dropped_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_clear && dir_write && host_wr_en && !be_pattern_ok(host_wr_be) && fifo_empty)
        |=> fifo_empty);

    assert_read_mode_ignores_host_wr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!dir_write && host_wr_en && !card_push_en && fifo_empty) |=> fifo_empty);

    assert_clear_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_clear |=> (fifo_empty && !dma_rd_evt && !dma_wr_evt));

endmodule

bind xfer_fifo_dma xfer_fifo_dma_checker u_xfer_fifo_dma_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .fifo_clear   (fifo_clear),
    .dir_write    (dir_write),
    .host_wr_en   (host_wr_en),
    .host_wr_be   (host_wr_be),
    .card_push_en (card_push_en),
    .dma_ack      (dma_ack),
    .dma_rd_evt   (dma_rd_evt),
    .dma_wr_evt   (dma_wr_evt),
    .fifo_full    (fifo_full),
    .fifo_empty   (fifo_empty)
);

// File: tb/xfer_fifo_dma_bench.sv
// Bench: directed corner cases, then seeded random traffic, compared each
// cycle against a model written from the requirements.
module xfer_fifo_dma_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;
    localparam int SEED       = 32'h5eed_1234;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fifo_clear = 1'b0;
    logic        dir_write = 1'b0;
    logic        level_sel = 1'b0;
    logic        host_wr_en = 1'b0;
    logic [31:0] host_wr_data = '0;
    logic [3:0]  host_wr_be = 4'hF;
    logic        host_rd_en = 1'b0;
    logic        card_push_en = 1'b0;
    logic [31:0] card_push_data = '0;
    logic        card_pop_en = 1'b0;
    logic        dma_ack = 1'b0;
    logic [31:0] host_rd_data;
    logic [31:0] card_pop_data;
    logic [3:0]  card_pop_be;
    logic        dma_rd_evt, dma_wr_evt, irq_rd_evt, irq_wr_evt;
    logic        fifo_full, fifo_empty;

    int checks = 0;
    int fails  = 0;

    logic [35:0] mq[$];
    int          m_cnt = 0;
    bit          m_pend = 0;
    bit          m_ev_rd = 0;
    bit          m_ev_wr = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xfer_fifo_dma u_xfer_fifo_dma (
        .clk(clk), .rst_n(rst_n), .fifo_clear(fifo_clear), .dir_write(dir_write),
        .level_sel(level_sel), .host_wr_en(host_wr_en), .host_wr_data(host_wr_data),
        .host_wr_be(host_wr_be), .host_rd_en(host_rd_en), .host_rd_data(host_rd_data),
        .card_push_en(card_push_en), .card_push_data(card_push_data),
        .card_pop_en(card_pop_en), .card_pop_data(card_pop_data), .card_pop_be(card_pop_be),
        .dma_ack(dma_ack), .dma_rd_evt(dma_rd_evt), .dma_wr_evt(dma_wr_evt),
        .irq_rd_evt(irq_rd_evt), .irq_wr_evt(irq_wr_evt),
        .fifo_full(fifo_full), .fifo_empty(fifo_empty)
    );

    function automatic bit legal_be(input logic [3:0] be);
        return (be == 4'b1111) || (be == 4'b1110) || (be == 4'b1100) || (be == 4'b1000);
    endfunction

    function automatic logic [31:0] mask_word(input logic [31:0] d, input logic [3:0] be);
        logic [31:0] r;
        for (int l = 0; l < 4; l++) r[l*8 +: 8] = be[l] ? d[l*8 +: 8] : 8'h00;
        return r;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
        end
    endtask

    // Model step for one clock edge, from the requirements.
    task automatic model_update();
        int          sz;
        int          lvl;
        int          sum;
        bit          push_req, pop_req, do_push, do_pop, mv, fire;
        logic [35:0] entry;
        if (fifo_clear) begin
            mq.delete();
            m_cnt = 0; m_pend = 0; m_ev_rd = 0; m_ev_wr = 0;
            return;
        end
        sz       = mq.size();
        push_req = dir_write ? (host_wr_en && legal_be(host_wr_be)) : card_push_en;
        pop_req  = dir_write ? card_pop_en : host_rd_en;
        do_pop   = pop_req && (sz != 0);
        do_push  = push_req && (sz != DEPTH);
        entry    = dir_write ? {host_wr_be, mask_word(host_wr_data, host_wr_be)}
                             : {4'hF, card_push_data};
        if (do_pop) void'(mq.pop_front());
        if (do_push) mq.push_back(entry);
        mv   = dir_write ? do_pop : do_push;
        lvl  = level_sel ? 8 : 4;
        sum  = m_cnt + int'(mv);
        fire = (sum >= lvl) && !m_pend;
        m_cnt   = fire ? 0 : ((sum >= lvl) ? lvl : sum);
        m_pend  = fire ? 1'b1 : (m_pend && !dma_ack);
        m_ev_rd = fire && !dir_write;
        m_ev_wr = fire && dir_write;
    endtask

    task automatic compare();
        bit e;
        e = (mq.size() == 0);
        chk(fifo_full == (mq.size() == DEPTH), "R3 full", 36'(fifo_full), 36'(mq.size() == DEPTH));
        chk(fifo_empty == e, "R3 empty", 36'(fifo_empty), 36'(e));
        chk(dma_rd_evt == m_ev_rd, "R4 dma_rd_evt", 36'(dma_rd_evt), 36'(m_ev_rd));
        chk(dma_wr_evt == m_ev_wr, "R5 dma_wr_evt", 36'(dma_wr_evt), 36'(m_ev_wr));
        chk(irq_rd_evt == m_ev_rd, "R6 irq_rd_evt", 36'(irq_rd_evt), 36'(m_ev_rd));
        chk(irq_wr_evt == m_ev_wr, "R6 irq_wr_evt", 36'(irq_wr_evt), 36'(m_ev_wr));
        if (!e) begin
            chk(host_rd_data == mq[0][31:0], "R2 host_rd_data", 36'(host_rd_data), 36'(mq[0][31:0]));
            chk(card_pop_data == mq[0][31:0], "R2 card_pop_data", 36'(card_pop_data), 36'(mq[0][31:0]));
            chk(card_pop_be == mq[0][35:32], "R8 card_pop_be", 36'(card_pop_be), 36'(mq[0][35:32]));
        end
    endtask

    // One clock: inputs already set; model and compare after the edge.
    task automatic cycle();
        @(posedge clk);
        @(negedge clk);
        model_update();
        compare();
    endtask

    task automatic idle();
        fifo_clear = 0; host_wr_en = 0; host_rd_en = 0;
        card_push_en = 0; card_pop_en = 0; dma_ack = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++; fails++;
        $display("FAIL watchdog: actual=timeout expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(SEED));
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(fifo_empty === 1'b1, "R1 empty", 36'(fifo_empty), 36'd1);
        chk(fifo_full === 1'b0, "R1 full", 36'(fifo_full), 36'd0);
        chk({dma_rd_evt, dma_wr_evt, irq_rd_evt, irq_wr_evt} === 4'b0, "R1 events",
            36'({dma_rd_evt, dma_wr_evt, irq_rd_evt, irq_wr_evt}), 36'd0);
        rst_n = 1;

        // R4: card-read, level 4, then drain by host with ack
        idle(); dir_write = 0; level_sel = 0;
        for (int i = 0; i < 5; i++) begin
            card_push_en = 1; card_push_data = 32'hA000_0000 + i; cycle();
        end
        idle(); dma_ack = 1; host_rd_en = 1;
        for (int i = 0; i < 5; i++) cycle();
        idle();

        // R5/R8: card-write, level 8, legal partial enables
        dir_write = 1; level_sel = 1;
        for (int i = 0; i < 17; i++) begin
            host_wr_en = 1; host_wr_data = 32'hC0DE_0000 + i;
            case (i % 4) 0: host_wr_be = 4'b1111; 1: host_wr_be = 4'b1110;
                         2: host_wr_be = 4'b1100; default: host_wr_be = 4'b1000; endcase
            cycle();
        end
        idle(); card_pop_en = 1;
        for (int i = 0; i < 17; i++) cycle();
        idle();

        // R8: illegal enables ignored
        host_wr_en = 1; host_wr_be = 4'b0110; host_wr_data = 32'h1234_5678; cycle();
        chk(fifo_empty == 1'b1, "R8 illegal be ignored", 36'(fifo_empty), 36'd1);
        host_wr_be = 4'b0001; cycle();
        chk(fifo_empty == 1'b1, "R8 illegal be ignored", 36'(fifo_empty), 36'd1);
        idle();

        // R9: wrong-side strobes ignored in each mode
        card_push_en = 1; card_push_data = 32'hDEAD_BEEF; cycle();
        chk(fifo_empty == 1'b1, "R9 card push in write mode", 36'(fifo_empty), 36'd1);
        idle(); dir_write = 0; host_wr_en = 1; host_wr_be = 4'hF; cycle();
        chk(fifo_empty == 1'b1, "R9 host write in read mode", 36'(fifo_empty), 36'd1);
        idle(); fifo_clear = 1; cycle(); idle();

        // R7: pending blocks new events; event one cycle after ack
        level_sel = 0;
        for (int i = 0; i < 8; i++) begin
            card_push_en = 1; card_push_data = 32'hB000_0000 + i; cycle();
            if (i >= 4) chk(dma_rd_evt == 1'b0, "R7 no event while pending", 36'(dma_rd_evt), 36'd0);
        end
        idle(); dma_ack = 1; cycle();
        chk(dma_rd_evt == 1'b0, "R7 event not yet", 36'(dma_rd_evt), 36'd0);
        idle(); cycle();
        chk(dma_rd_evt == 1'b1, "R7 event after ack", 36'(dma_rd_evt), 36'd1);

        // R10: clear with a push and a pending event
        fifo_clear = 1; card_push_en = 1; cycle();
        chk(fifo_empty == 1'b1, "R10 cleared", 36'(fifo_empty), 36'd1);
        idle();
        for (int i = 0; i < 4; i++) begin
            card_push_en = 1; card_push_data = 32'hE000_0000 + i; cycle();
        end
        chk(dma_rd_evt == 1'b1, "R10 pending dropped", 36'(dma_rd_evt), 36'd1);
        idle(); fifo_clear = 1; cycle(); idle();

        // Random traffic
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 299) == 0) dir_write = ~dir_write;
            if ($urandom_range(0, 99) == 0) level_sel = ~level_sel;
            fifo_clear     = ($urandom_range(0, 249) == 0);
            host_wr_en     = ($urandom_range(0, 1) == 0);
            host_wr_data   = $urandom;
            case ($urandom_range(0, 4))
                0: host_wr_be = 4'b1111; 1: host_wr_be = 4'b1110;
                2: host_wr_be = 4'b1100; 3: host_wr_be = 4'b1000;
                default: host_wr_be = 4'($urandom);
            endcase
            host_rd_en     = ($urandom_range(0, 1) == 0);
            card_push_en   = ($urandom_range(0, 1) == 0);
            card_push_data = $urandom;
            card_pop_en    = ($urandom_range(0, 1) == 0);
            dma_ack        = ($urandom_range(0, 3) == 0);
            cycle();
        end
        idle();

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule